// File: doc/BRIEF.md
# Four-Way Set-Associative Data Cache

This block sits between a processor load/store unit and a slower word-wide memory. It holds recently used lines in a four-way set-associative array. Each line carries four 32-bit words, one valid bit and one dirty bit per word. The processor issues one word read or write at a time over a ready/valid request with a single-cycle response pulse. Misses are served over a separate memory port that moves one word per request/acknowledge exchange.

A runtime input selects the write policy. In write-back mode, writes stay in the cache, and only the modified words of a victim are sent to memory when the line is replaced. In write-through mode, every write goes to memory, and write misses leave the cache untouched. The victim way is chosen by a free-running pseudo-random generator, but an empty way is always used first. A flush input empties the whole cache in one cycle and discards any modified data.

Top module: `dcache_4way`

## Requirements
- R1: While reset is held and on the first cycle after it, `cpu_rsp_valid` and `mem_req` are low. All lines start invalid, so the first read of any address goes to memory.
- R2: A byte address splits into word select in bits [3:2], set index in bits [IDX_W+3:4] and tag in the bits above. Four lines with different tags and the same index can be resident together.
- R3: A read hit raises `cpu_rsp_valid` for one cycle, in the cycle after the second rising edge counted from acceptance. It returns the stored word and makes no memory request.
- R4: A read miss fetches the four words of the line from word 0 upward, at the line base address. The response comes only after the fourth acknowledge and carries the requested word.
- R5: On a miss, the lowest-numbered invalid way of the set is filled. When all four ways are valid, the way named by the two low bits of a 16-bit LFSR is replaced.
- R6: Before a fill, the victim's dirty words are written to memory one request each, in ascending word order, at the victim's own address. A victim with no dirty word causes no write.
- R7: In write-back mode (`wb_mode`=1), a write hit updates the cached word, marks that word dirty and makes no memory request.
- R8: In write-back mode, a write miss allocates the line (eviction if needed, then a four-word fill) and then merges the written word as dirty.
- R9: In write-through mode (`wb_mode`=0), a write hit updates the cached word and issues exactly one memory write of that word. Dirty bits are left unchanged.
- R10: In write-through mode, a write miss issues exactly one memory write and does not allocate a line.
- R11: `flush` acts only while the controller is idle. It clears all valid and dirty bits in one cycle, writes nothing back, and holds `cpu_req_ready` low while it is high.
- R12: Once raised, `mem_req` stays high with stable `mem_we`, `mem_addr` and `mem_wdata` until `mem_ack` is seen.
- R13: `cpu_req_ready` is high only while the controller is idle. Each accepted request produces exactly one single-cycle response, and never while `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_mode | input | 1 | 1 = write-back, 0 = write-through |
| flush | input | 1 | Invalidate every line (idle only) |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache accepts a request this cycle |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Word-aligned byte address |
| cpu_req_wdata | input | DATA_W | Write data |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read data, valid with the pulse |
| mem_req | output | 1 | Memory request held until acknowledged |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Word address of the memory access |
| mem_wdata | output | DATA_W | Data for a memory write |
| mem_ack | input | 1 | One-cycle acknowledge; completes the request |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |

## Verification
The bench builds the cache with SETS=4 and keeps four ways and four words per line. The index then sits in address bits [5:4] and the tag starts at bit 6. With so few sets, a handful of small addresses fills a whole set. This exercises invalid-way preference, random replacement of a full set, and dirty-word eviction order without sweeping a large address space. Because every line of a set can hold the same dirty-word pattern, the eviction traffic can be checked word by word even though the victim itself is chosen at random.

// File: rtl/dcache_pkg.sv
// Shared types for the set-associative data cache.
// Assumes a single controller instance per package use; no parameters here.
package dcache_pkg;

    // Controller phases: idle, tag compare, victim write-back, line fill, write-through store
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CMP   = 3'd1,
        ST_EVICT = 3'd2,
        ST_FILL  = 3'd3,
        ST_WTW   = 3'd4
    } dc_state_t;

endpackage

// File: rtl/dc_lfsr.sv
// Free-running 16-bit Fibonacci LFSR (taps 16,14,13,11) used for random victim choice.
// Assumes SEED is non-zero; exposes only the low OUT_W bits.
module dc_lfsr #(
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter int          OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);
    logic [15:0] q;
    logic        fb;

    // feedback bit from the tap positions
    always_comb fb = q[15] ^ q[13] ^ q[12] ^ q[10];

    // shift every cycle, reload seed on reset
    always_ff @(posedge clk) begin
        if (!rst_n) q <= SEED;
        else        q <= {q[14:0], fb};
    end

    assign rnd_o = q[OUT_W-1:0];
endmodule

// File: rtl/dc_tag_match.sv
// Compares one request tag against all ways of a set.
// Assumes at most one valid way matches (guaranteed by the fill policy).
module dc_tag_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 22,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0][TAG_W-1:0] tags_i,
    input  logic [WAYS-1:0]            valid_i,
    input  logic [TAG_W-1:0]           tag_i,
    output logic                       hit_o,
    output logic [WAY_W-1:0]           way_o
);
    logic [WAYS-1:0] match;

    genvar g;
    generate
        for (g = 0; g < WAYS; g++) begin : g_cmp
            assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
        end
    endgenerate

    // encode the matching way
    always_comb begin
        way_o = '0;
        for (int i = 0; i < WAYS; i++)
            if (match[i]) way_o = WAY_W'(i);
    end

    assign hit_o = |match;
endmodule

// File: rtl/dc_victim_pick.sv
// Chooses the way to replace: lowest invalid way, else the random way.
// Assumes rnd_i is already reduced to a legal way number.
module dc_victim_pick #(
    parameter int WAYS = 4,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]  valid_i,
    input  logic [WAY_W-1:0] rnd_i,
    output logic [WAY_W-1:0] way_o
);
    // priority scan from the top so the lowest invalid way wins
    always_comb begin
        way_o = rnd_i;
        for (int i = WAYS - 1; i >= 0; i--)
            if (!valid_i[i]) way_o = WAY_W'(i);
    end
endmodule

// File: rtl/dc_first_set.sv
// Finds the lowest set bit of a word mask (next dirty word to write back).
// Assumes the caller qualifies idx_o with any_o.
module dc_first_set #(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // downward scan leaves the lowest set index
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--)
            if (mask_i[i]) idx_o = IW'(i);
    end

    assign any_o = |mask_i;
endmodule

// File: rtl/dcache_4way.sv
// Set-associative data cache with per-word dirty bits and a runtime write policy.
// Processor side: ready/valid request, one-cycle response pulse. Memory side:
// word request held until a one-cycle acknowledge. Assumes word-aligned addresses
// and a blocking controller (one outstanding request).
module dcache_4way
    import dcache_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter int          DATA_W    = 32,
    parameter int          SETS      = 64,
    parameter int          WAYS      = 4,
    parameter int          WORDS     = 4,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wb_mode,
    input  logic              flush,
    input  logic              cpu_req_valid,
    output logic              cpu_req_ready,
    input  logic              cpu_req_we,
    input  logic [ADDR_W-1:0] cpu_req_addr,
    input  logic [DATA_W-1:0] cpu_req_wdata,
    output logic              cpu_rsp_valid,
    output logic [DATA_W-1:0] cpu_rsp_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    localparam int BOFF_W = $clog2(DATA_W / 8);
    localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1;
    localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int TAG_LO = BOFF_W + WSEL_W + IDX_W;
    localparam int TAG_W  = ADDR_W - TAG_LO;

    // storage
    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [DATA_W-1:0] data_q  [SETS][WAYS][WORDS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [WORDS-1:0]  dirty_q [SETS][WAYS];

    // controller state
    dc_state_t         state;
    logic              req_we;
    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;
    logic [DATA_W-1:0] req_wdata;
    logic [WAY_W-1:0]  vic_way;
    logic [TAG_W-1:0]  vic_tag;
    logic [WORDS-1:0]  vic_mask;
    logic [WSEL_W-1:0] fill_ptr;

    // helpers
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic                       hit;
    logic [WAY_W-1:0]           hit_way;
    logic [WAY_W-1:0]           rnd_way;
    logic [WAY_W-1:0]           pick_way;
    logic                       ev_any;
    logic [WSEL_W-1:0]          ev_ptr;
    logic [WORDS-1:0]           vic_mask_nx;
    logic                       fill_last;
    logic                       fill_done;
    logic                       wr_hit;

    // gather the tags of the addressed set for comparison
    always_comb begin
        for (int w = 0; w < WAYS; w++) set_tags[w] = tag_q[req_idx][w];
    end

    dc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .tags_i  (set_tags),
        .valid_i (valid_q[req_idx]),
        .tag_i   (req_tag),
        .hit_o   (hit),
        .way_o   (hit_way)
    );

    dc_lfsr #(.SEED(LFSR_SEED), .OUT_W(WAY_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd_way)
    );

    dc_victim_pick #(.WAYS(WAYS)) u_pick (
        .valid_i (valid_q[req_idx]),
        .rnd_i   (rnd_way),
        .way_o   (pick_way)
    );

    dc_first_set #(.N(WORDS)) u_scan (
        .mask_i (vic_mask),
        .any_o  (ev_any),
        .idx_o  (ev_ptr)
    );

    // victim mask after the current dirty word is acknowledged
    always_comb begin
        vic_mask_nx         = vic_mask;
        vic_mask_nx[ev_ptr] = 1'b0;
    end

    assign fill_last = (fill_ptr == WSEL_W'(WORDS - 1));
    assign fill_done = (state == ST_FILL) && mem_ack && fill_last;
    assign wr_hit    = (state == ST_CMP) && hit && req_we;

    // controller sequencing and processor response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state         <= ST_IDLE;
            cpu_rsp_valid <= 1'b0;
            cpu_rsp_rdata <= '0;
            req_we        <= 1'b0;
            req_tag       <= '0;
            req_idx       <= '0;
            req_wsel      <= '0;
            req_wdata     <= '0;
            vic_way       <= '0;
            vic_tag       <= '0;
            vic_mask      <= '0;
            fill_ptr      <= '0;
        end else begin
            cpu_rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!flush && cpu_req_valid) begin
                        req_we    <= cpu_req_we;
                        req_tag   <= cpu_req_addr[ADDR_W-1:TAG_LO];
                        req_idx   <= cpu_req_addr[TAG_LO-1:BOFF_W+WSEL_W];
                        req_wsel  <= cpu_req_addr[BOFF_W+WSEL_W-1:BOFF_W];
                        req_wdata <= cpu_req_wdata;
                        state     <= ST_CMP;
                    end
                end
                ST_CMP: begin
                    if (hit) begin
                        if (!req_we) begin
                            cpu_rsp_rdata <= data_q[req_idx][hit_way][req_wsel];
                            cpu_rsp_valid <= 1'b1;
                            state         <= ST_IDLE;
                        end else if (wb_mode) begin
                            cpu_rsp_valid <= 1'b1;
                            state         <= ST_IDLE;
                        end else begin
                            state <= ST_WTW;
                        end
                    end else if (req_we && !wb_mode) begin
                        state <= ST_WTW;
                    end else begin
                        vic_way  <= pick_way;
                        vic_tag  <= tag_q[req_idx][pick_way];
                        vic_mask <= valid_q[req_idx][pick_way] ?
                                    dirty_q[req_idx][pick_way] : '0;
                        fill_ptr <= '0;
                        state    <= (valid_q[req_idx][pick_way] &&
                                     (|dirty_q[req_idx][pick_way])) ? ST_EVICT : ST_FILL;
                    end
                end
                ST_EVICT: begin
                    if (mem_ack) begin
                        vic_mask <= vic_mask_nx;
                        if (vic_mask_nx == '0) state <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        fill_ptr <= fill_ptr + 1'b1;
                        if (fill_last) state <= ST_CMP;
                    end
                end
                ST_WTW: begin
                    if (mem_ack) begin
                        cpu_rsp_valid <= 1'b1;
                        state         <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // data and tag arrays: write hits and fill words
    always_ff @(posedge clk) begin
        if (wr_hit) data_q[req_idx][hit_way][req_wsel] <= req_wdata;
        if ((state == ST_FILL) && mem_ack) begin
            data_q[req_idx][vic_way][fill_ptr] <= mem_rdata;
            if (fill_last) tag_q[req_idx][vic_way] <= req_tag;
        end
    end

    // valid and dirty bits: flush, write-back marking, line install
    always_ff @(posedge clk) begin
        if (!rst_n || ((state == ST_IDLE) && flush)) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                for (int w = 0; w < WAYS; w++) dirty_q[s][w] <= '0;
            end
        end else begin
            if (wr_hit && wb_mode) dirty_q[req_idx][hit_way][req_wsel] <= 1'b1;
            if (fill_done) begin
                valid_q[req_idx][vic_way] <= 1'b1;
                dirty_q[req_idx][vic_way] <= '0;
            end
        end
    end

    // memory port and processor ready, decoded from state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state)
            ST_EVICT: begin
                mem_req   = ev_any;
                mem_we    = 1'b1;
                mem_addr  = {vic_tag, req_idx, ev_ptr, {BOFF_W{1'b0}}};
                mem_wdata = data_q[req_idx][vic_way][ev_ptr];
            end
            ST_FILL: begin
                mem_req  = 1'b1;
                mem_addr = {req_tag, req_idx, fill_ptr, {BOFF_W{1'b0}}};
            end
            ST_WTW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {req_tag, req_idx, req_wsel, {BOFF_W{1'b0}}};
                mem_wdata = req_wdata;
            end
            default: ;
        endcase
    end

    assign cpu_req_ready = (state == ST_IDLE) && !flush;
endmodule

// File: rtl/dcache_4way_chk.sv
// Protocol checker for dcache_4way, attached by bind. Observes ports only.
module dcache_4way_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              cpu_req_valid,
    input logic              cpu_req_ready,
    input logic              cpu_rsp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ack
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !cpu_rsp_valid));

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    // R11
    flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !cpu_req_ready);

    // R13
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_valid && cpu_req_ready) |=> !cpu_req_ready);

    // R13
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid);

    // R13
    rsp_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> !mem_req);
endmodule

bind dcache_4way dcache_4way_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .cpu_req_valid (cpu_req_valid),
    .cpu_req_ready (cpu_req_ready),
    .cpu_rsp_valid (cpu_rsp_valid),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack)
);

// File: tb/tb_dcache_4way.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, small set count, word memory model.
module tb_dcache_4way;
    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wb_mode = 1'b1;
    logic          flush = 1'b0;
    logic          cpu_req_valid = 1'b0;
    logic          cpu_req_ready;
    logic          cpu_req_we = 1'b0;
    logic [AW-1:0] cpu_req_addr = '0;
    logic [DW-1:0] cpu_req_wdata = '0;
    logic          cpu_rsp_valid;
    logic [DW-1:0] cpu_rsp_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    dcache_4way #(.SETS(4)) dut (.*);

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // memory model and access log
    logic [DW-1:0] store [logic [AW-1:0]];
    logic          log_we   [64];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int            log_n = 0;

    function automatic logic [DW-1:0] mdef(input logic [AW-1:0] a);
        return a ^ 32'h5A5A_0000;
    endfunction

    function automatic logic [DW-1:0] mread(input logic [AW-1:0] a);
        return store.exists(a) ? store[a] : mdef(a);
    endfunction

    // bench address: tag above bit 6, set in [5:4], word in [3:2]
    function automatic logic [AW-1:0] ad(input int t, input int s, input int w);
        return AW'((t << 6) | (s << 4) | (w << 2));
    endfunction

    function automatic logic [DW-1:0] pat(input int t, input int w);
        return 32'hD000_0000 | DW'(t << 8) | DW'(w);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // memory responder: acts on falling edges, one-cycle acknowledge
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack <= 1'b0;
            end else if (rst_n && mem_req) begin
                if (mem_we) store[mem_addr] = mem_wdata;
                else        mem_rdata <= mread(mem_addr);
                if (log_n < 64) begin
                    log_we[log_n]   = mem_we;
                    log_addr[log_n] = mem_addr;
                    log_data[log_n] = mem_we ? mem_wdata : mread(mem_addr);
                end
                log_n++;
                mem_ack <= 1'b1;
            end
        end
    end

    // one processor access; returns read data and response latency in cycles
    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int lat);
        @(negedge clk);
        log_n = 0;
        cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd; cpu_req_valid = 1'b1;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 1;
        while (!cpu_rsp_valid && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        rd = cpu_rsp_rdata;
        chk(cpu_rsp_valid, "R13", "response seen", DW'(cpu_rsp_valid), 1);
    endtask

    function automatic int n_writes();
        int c = 0;
        for (int i = 0; i < log_n && i < 64; i++) if (log_we[i]) c++;
        return c;
    endfunction

    // R4: verify log entries from..from+3 are a full ascending line fill of line t/s
    task automatic chk_fill(input int from, input int t, input int s);
        for (int w = 0; w < 4; w++)
            chk(!log_we[from+w] && log_addr[from+w] == ad(t, s, w), "R4",
                "fill order", log_addr[from+w], ad(t, s, w));
    endtask

    task automatic t_reset();
        logic [DW-1:0] rd; int lat;
        chk(cpu_req_ready, "R1", "ready after reset", DW'(cpu_req_ready), 1);
        chk(!cpu_rsp_valid && !mem_req, "R1", "quiet after reset",
            DW'({cpu_rsp_valid, mem_req}), 0);
        access(0, ad(1, 0, 2), 0, rd, lat);
        chk(log_n == 4, "R1", "first read misses", DW'(log_n), 4);
        chk_fill(0, 1, 0);
        chk(rd == mdef(ad(1, 0, 2)), "R4", "miss data", rd, mdef(ad(1, 0, 2)));
        access(0, ad(1, 0, 0), 0, rd, lat);
        chk(log_n == 0, "R3", "hit no traffic", DW'(log_n), 0);
        chk(lat == 2, "R3", "hit latency", DW'(lat), 2);
        chk(rd == mdef(ad(1, 0, 0)), "R3", "hit data", rd, mdef(ad(1, 0, 0)));
        repeat (3) begin
            @(negedge clk);
            chk(!cpu_rsp_valid, "R13", "single response", DW'(cpu_rsp_valid), 0);
        end
    endtask

    task automatic t_four_ways();
        logic [DW-1:0] rd; int lat; int misses = 0;
        for (int t = 1; t <= 4; t++) access(0, ad(t, 1, 0), 0, rd, lat);
        for (int t = 1; t <= 4; t++) begin
            access(0, ad(t, 1, 3), 0, rd, lat);
            if (log_n != 0) misses++;
            chk(rd == mdef(ad(t, 1, 3)), "R2", "resident data", rd, mdef(ad(t, 1, 3)));
        end
        chk(misses == 0, "R5", "invalid ways filled first", DW'(misses), 0);
    endtask

    task automatic t_wb_writes();
        logic [DW-1:0] rd; int lat;
        wb_mode = 1'b1;
        access(1, ad(1, 1, 3), 32'hCAFE_0013, rd, lat);
        chk(log_n == 0, "R7", "wb hit no traffic", DW'(log_n), 0);
        access(0, ad(1, 1, 3), 0, rd, lat);
        chk(rd == 32'hCAFE_0013, "R7", "wb hit data", rd, 32'hCAFE_0013);
        access(1, ad(7, 2, 1), 32'hBEEF_0721, rd, lat);
        chk(log_n == 4 && n_writes() == 0, "R8", "wb miss fills", DW'(log_n), 4);
        chk_fill(0, 7, 2);
        access(0, ad(7, 2, 1), 0, rd, lat);
        chk(log_n == 0 && rd == 32'hBEEF_0721, "R8", "merged word", rd, 32'hBEEF_0721);
    endtask

    task automatic t_evict_order();
        logic [DW-1:0] rd; int lat; int vt;
        wb_mode = 1'b1;
        for (int t = 1; t <= 4; t++) begin
            access(1, ad(t, 3, 1), pat(t, 1), rd, lat);
            access(1, ad(t, 3, 3), pat(t, 3), rd, lat);
        end
        access(0, ad(9, 3, 0), 0, rd, lat);
        chk(log_n == 6, "R6", "evict plus fill count", DW'(log_n), 6);
        vt = int'(log_addr[0] >> 6);
        chk(vt >= 1 && vt <= 4, "R5", "victim from full set", DW'(vt), 1);
        chk(log_we[0] && log_addr[0] == ad(vt, 3, 1) && log_data[0] == pat(vt, 1),
            "R6", "first dirty word", log_data[0], pat(vt, 1));
        chk(log_we[1] && log_addr[1] == ad(vt, 3, 3) && log_data[1] == pat(vt, 3),
            "R6", "second dirty word", log_data[1], pat(vt, 3));
        chk_fill(2, 9, 3);
        access(0, ad(9, 3, 0), 0, rd, lat);
        chk(log_n == 0, "R5", "new line resident", DW'(log_n), 0);
        // clean victim: set 0 holds clean line 1; add 2..4, then a fifth
        for (int t = 2; t <= 4; t++) access(0, ad(t, 0, 0), 0, rd, lat);
        access(0, ad(5, 0, 0), 0, rd, lat);
        chk(log_n == 4 && n_writes() == 0, "R6", "clean victim no write",
            DW'(n_writes()), 0);
    endtask

    task automatic t_write_through();
        logic [DW-1:0] rd; int lat;
        wb_mode = 1'b0;
        access(1, ad(5, 0, 2), 32'h1234_5052, rd, lat);
        chk(log_n == 1 && log_we[0] && log_addr[0] == ad(5, 0, 2) &&
            log_data[0] == 32'h1234_5052, "R9", "wt hit one write",
            log_data[0], 32'h1234_5052);
        access(0, ad(5, 0, 2), 0, rd, lat);
        chk(log_n == 0 && rd == 32'h1234_5052, "R9", "wt hit cached", rd, 32'h1234_5052);
        access(1, ad(20, 2, 0), 32'h0000_2020, rd, lat);
        chk(log_n == 1 && log_we[0] && log_addr[0] == ad(20, 2, 0), "R10",
            "wt miss one write", log_addr[0], ad(20, 2, 0));
        access(0, ad(20, 2, 0), 0, rd, lat);
        chk(log_n == 4, "R10", "no allocation", DW'(log_n), 4);
        chk(rd == 32'h0000_2020, "R10", "memory updated", rd, 32'h0000_2020);
    endtask

    task automatic t_flush();
        logic [DW-1:0] rd; int lat;
        wb_mode = 1'b1;
        access(1, ad(1, 1, 2), 32'hDEAD_0112, rd, lat);
        chk(log_n == 0, "R7", "dirty hit before flush", DW'(log_n), 0);
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk(!cpu_req_ready, "R11", "ready low in flush", DW'(cpu_req_ready), 0);
        @(negedge clk);
        flush = 1'b0;
        access(0, ad(1, 1, 2), 0, rd, lat);
        chk(log_n == 4 && n_writes() == 0, "R11", "invalid, no write-back",
            DW'(n_writes()), 0);
        chk(rd == mdef(ad(1, 1, 2)), "R11", "dirty data dropped", rd, mdef(ad(1, 1, 2)));
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_four_ways();
        t_wb_writes();
        t_evict_order();
        t_write_through();
        t_flush();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule